// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block is a slave-side serial port for stereo PCM audio. It samples an external bit clock and frame clock, along with one serial input line, into the system clock domain through synchronizers. It assembles left and right words from the serial stream and presents each completed pair as parallel samples with a one-cycle valid pulse. In the same frame it serializes a parallel left/right pair onto a serial output line.

Four framings are available: I2S, left-justified, right-justified and DSP. There are four word widths. Two static configuration inputs select the framing and the width, and the all-zero setting gives I2S with 24-bit words. Samples on the parallel side are always 24 bits wide and MSB-aligned. A word narrower than 24 bits occupies the upper bits.

Top module: `audio_serial_port`

## Requirements
- R1: After reset is released, `rxValid`, `txTaken` and `sdOut` are low, and `rxLeft` and `rxRight` are zero.
- R2: `cfgFmt` encodes 0 = I2S, 1 = left-justified, 2 = right-justified, 3 = DSP. In I2S, a low frame clock marks the left channel, and the MSB occupies the second bit period after each frame-clock transition.
- R3: In left-justified mode, a high frame clock marks the left channel, and the MSB occupies the first bit period after each frame-clock transition.
- R4: In right-justified mode, a high frame clock marks the left channel, and the LSB occupies the last of the `HALF_BITS` (default 32) bit periods of each half-frame. This mode requires half-frames of exactly `HALF_BITS` bit clocks.
- R5: In DSP mode, only a rising edge of the frame clock matters. The left MSB occupies the bit period in which the rise is seen, and the right MSB immediately follows the left LSB. How long the frame clock then stays high has no effect.
- R6: `cfgWidth` encodes 0 = 24, 1 = 20, 2 = 18, 3 = 16 bits. Received words are MSB-aligned in 24 bits with the unused low bits zero, and transmitted words are taken from the upper bits of the 24-bit inputs.
- R7: Serial input is sampled on rising bit-clock edges. Bits outside the word window of the current format and width have no effect on the received samples.
- R8: `rxValid` pulses for exactly one clock after the right-channel LSB of a frame is captured, provided the left word of that frame was captured before it. `rxLeft` and `rxRight` then hold the new pair.
- R9: `sdOut` changes only after a falling bit-clock edge. It carries the word bits in the window of the selected format and width, and it is zero elsewhere.
- R10: `txTaken` pulses for one clock when `txLeft` and `txRight` are latched, at the start of the left half-frame (the frame-clock rise in DSP mode). The latched pair is the one sent in that frame, even if the inputs change later in the frame.
- R11: Outside right-justified mode, the bit clock may pause in its low phase without changing either the received or the transmitted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgFmt | input | 2 | Framing select |
| cfgWidth | input | 2 | Word width select |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External frame clock |
| sdIn | input | 1 | Serial receive data |
| txLeft | input | 24 | Left sample to transmit, MSB-aligned |
| txRight | input | 24 | Right sample to transmit, MSB-aligned |
| sdOut | output | 1 | Serial transmit data |
| txTaken | output | 1 | Pulse: transmit pair latched |
| rxLeft | output | 24 | Received left sample, MSB-aligned |
| rxRight | output | 24 | Received right sample, MSB-aligned |
| rxValid | output | 1 | Pulse: new received pair |

## Verification
The assertions assume that each phase of the bit clock lasts at least five system clocks. This is longer than the synchronizer, edge detect and output register path, so every serial-output change and every `txTaken` pulse lands while the bit clock is still low, and every `rxValid` pulse lands while it is high. They also assume that the frame clock and serial input change only together with a falling bit-clock edge, and that bursts stretch only the low phase. The stimulus holds each phase for six system clocks. It changes `lrclk` and `sdIn` in the same step that lowers `bclk`, and it inserts burst pauses only after a falling edge.

// File: rtl/asp_pkg.sv
package asp_pkg;

  localparam int SAMPLE_W = 24;
  localparam int IDX_W    = 5;
  localparam int POS_W    = 8;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } aspFmt_e;

  // Where one bit period sits inside the framing.
  typedef struct packed {
    logic             inWord;
    logic             isRight;
    logic [IDX_W-1:0] idx;
    logic             isLast;
  } slot_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             rxShift;
    logic             rxLast;
    logic             rxRight;
    logic             rxBit;
    logic             txLoad;
    logic             txDrive;
    logic             txActive;
    logic             txRight;
    logic [IDX_W-1:0] txIdx;
    logic [IDX_W-1:0] alignShift;
  } aspStrobe_t;

  function automatic logic [IDX_W-1:0] widthOf(input logic [1:0] code);
    case (code)
      2'd0:    return IDX_W'(24);
      2'd1:    return IDX_W'(20);
      2'd2:    return IDX_W'(18);
      default: return IDX_W'(16);
    endcase
  endfunction

  function automatic slot_t classify(input aspFmt_e fmt,
                                     input logic [IDX_W-1:0] w,
                                     input logic [POS_W-1:0] pos,
                                     input logic lr,
                                     input logic [POS_W-1:0] halfLen);
    slot_t s;
    logic [POS_W-1:0] w8, first, rel;
    s = '0;
    w8 = POS_W'(w);
    first = '0;
    if (fmt == FMT_DSP) begin
      s.isRight = (pos >= w8);
      rel = s.isRight ? pos - w8 : pos;
      s.inWord = (pos < (w8 << 1));
    end else begin
      s.isRight = (fmt == FMT_I2S) ? lr : ~lr;
      case (fmt)
        FMT_I2S: first = POS_W'(1);
        FMT_LJ:  first = '0;
        default: first = halfLen - w8;
      endcase
      s.inWord = (pos >= first) && (pos < first + w8);
      rel = pos - first;
    end
    s.idx = rel[IDX_W-1:0];
    s.isLast = s.inWord && (rel == w8 - POS_W'(1));
    return s;
  endfunction

endpackage

// File: rtl/asp_phase.sv
module asp_phase
  import asp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  input  logic             isDsp,
  input  logic             lr,
  output logic [POS_W-1:0] posNow,
  output logic             primed
);

  logic             prevLr;
  logic [POS_W-1:0] posQ;
  logic             frameHit;

  always_comb begin
    frameHit = isDsp ? (lr & ~prevLr) : (lr ^ prevLr);
    if (!primed)       posNow = '1;
    else if (frameHit) posNow = '0;
    else if (&posQ)    posNow = posQ;
    else               posNow = posQ + POS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primed <= 1'b0;
      prevLr <= 1'b0;
      posQ   <= '1;
    end else if (step) begin
      primed <= 1'b1;
      prevLr <= lr;
      posQ   <= posNow;
    end
  end

endmodule

// File: rtl/asp_ctrl.sv
module asp_ctrl
  import asp_pkg::*;
#(
  parameter int HALF_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgFmt,
  input  logic [1:0] cfgWidth,
  input  logic       bclk,
  input  logic       lrclk,
  input  logic       sdIn,
  output aspStrobe_t strb
);

  localparam logic [POS_W-1:0] HALF_LEN = POS_W'(HALF_BITS);

  logic [SYNC_STAGES:0]   bPipe;
  logic [SYNC_STAGES-1:0] lrPipe;
  logic [SYNC_STAGES-1:0] sdPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bPipe  <= '0;
      lrPipe <= '0;
      sdPipe <= '0;
    end else begin
      bPipe  <= {bPipe[SYNC_STAGES-1:0], bclk};
      lrPipe <= {lrPipe[SYNC_STAGES-2:0], lrclk};
      sdPipe <= {sdPipe[SYNC_STAGES-2:0], sdIn};
    end
  end

  logic bRise, bFall, lrNow, sdNow, isDsp;
  aspFmt_e fmt;
  logic [IDX_W-1:0] wordW;

  assign bRise = bPipe[SYNC_STAGES-1] & ~bPipe[SYNC_STAGES];
  assign bFall = ~bPipe[SYNC_STAGES-1] & bPipe[SYNC_STAGES];
  assign lrNow = lrPipe[SYNC_STAGES-1];
  assign sdNow = sdPipe[SYNC_STAGES-1];
  assign fmt   = aspFmt_e'(cfgFmt);
  assign isDsp = (fmt == FMT_DSP);
  assign wordW = widthOf(cfgWidth);

  logic [1:0]       stepVec;
  logic [1:0]       primVec;
  logic [POS_W-1:0] posArr [2];

  assign stepVec = {bFall, bRise};

  // Index 0 tracks receive (rising edges), index 1 transmit (falling edges).
  for (genvar g = 0; g < 2; g++) begin : g_phase
    asp_phase u_phase (
      .clk    (clk),
      .rstN   (rstN),
      .step   (stepVec[g]),
      .isDsp  (isDsp),
      .lr     (lrNow),
      .posNow (posArr[g]),
      .primed (primVec[g])
    );
  end

  slot_t rxSlot, txSlot;

  always_comb begin
    rxSlot = classify(fmt, wordW, posArr[0], lrNow, HALF_LEN);
    txSlot = classify(fmt, wordW, posArr[1], lrNow, HALF_LEN);

    strb.rxShift    = bRise && primVec[0] && rxSlot.inWord;
    strb.rxLast     = bRise && primVec[0] && rxSlot.isLast;
    strb.rxRight    = rxSlot.isRight;
    strb.rxBit      = sdNow;
    strb.txDrive    = bFall && primVec[1];
    strb.txLoad     = bFall && primVec[1] && (posArr[1] == '0) &&
                      (isDsp || !txSlot.isRight);
    strb.txActive   = txSlot.inWord;
    strb.txRight    = txSlot.isRight;
    strb.txIdx      = txSlot.idx;
    strb.alignShift = IDX_W'(SAMPLE_W) - wordW;
  end

endmodule

// File: rtl/asp_datapath.sv
module asp_datapath
  import asp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  aspStrobe_t          strb,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid,
  output logic                txTaken,
  output logic                sdOut
);

  logic [SAMPLE_W-1:0] rxSh, holdL, latL, latR;
  logic                haveL;
  logic [SAMPLE_W-1:0] rxFull, rxAligned, srcL, srcR, txWord;
  logic                txBit;

  always_comb begin
    rxFull    = {rxSh[SAMPLE_W-2:0], strb.rxBit};
    rxAligned = rxFull << strb.alignShift;
    srcL      = strb.txLoad ? txLeft  : latL;
    srcR      = strb.txLoad ? txRight : latR;
    txWord    = strb.txRight ? srcR : srcL;
    txBit     = txWord[IDX_W'(SAMPLE_W - 1) - strb.txIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh    <= '0;
      holdL   <= '0;
      haveL   <= 1'b0;
      rxLeft  <= '0;
      rxRight <= '0;
      rxValid <= 1'b0;
      latL    <= '0;
      latR    <= '0;
      txTaken <= 1'b0;
      sdOut   <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      txTaken <= 1'b0;
      if (strb.rxShift) rxSh <= rxFull;
      if (strb.rxLast) begin
        if (!strb.rxRight) begin
          holdL <= rxAligned;
          haveL <= 1'b1;
        end else begin
          haveL <= 1'b0;
          if (haveL) begin
            rxLeft  <= holdL;
            rxRight <= rxAligned;
            rxValid <= 1'b1;
          end
        end
      end
      if (strb.txLoad) begin
        latL    <= txLeft;
        latR    <= txRight;
        txTaken <= 1'b1;
      end
      if (strb.txDrive) sdOut <= strb.txActive ? txBit : 1'b0;
    end
  end

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int HALF_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          cfgFmt,
  input  logic [1:0]          cfgWidth,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                sdIn,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                sdOut,
  output logic                txTaken,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);

  aspStrobe_t strb;

  asp_ctrl #(
    .HALF_BITS   (HALF_BITS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgFmt   (cfgFmt),
    .cfgWidth (cfgWidth),
    .bclk     (bclk),
    .lrclk    (lrclk),
    .sdIn     (sdIn),
    .strb     (strb)
  );

  asp_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .txLeft  (txLeft),
    .txRight (txRight),
    .rxLeft  (rxLeft),
    .rxRight (rxRight),
    .rxValid (rxValid),
    .txTaken (txTaken),
    .sdOut   (sdOut)
  );

endmodule

// File: rtl/asp_checker.sv
module asp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        bclk,
  input logic        sdOut,
  input logic        txTaken,
  input logic [23:0] rxLeft,
  input logic [23:0] rxRight,
  input logic        rxValid
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!rxValid && !txTaken && !sdOut && rxLeft == '0 && rxRight == '0));

  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_valid_in_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> bclk);

  p_tx_moves_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdOut) |-> !bclk);

  p_take_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    txTaken |=> !txTaken);

  p_take_in_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    txTaken |-> !bclk);

endmodule

bind audio_serial_port asp_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .bclk    (bclk),
  .sdOut   (sdOut),
  .txTaken (txTaken),
  .rxLeft  (rxLeft),
  .rxRight (rxRight),
  .rxValid (rxValid)
);

// File: tb/audio_serial_port_tb.sv
module audio_serial_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_PH    = 6;
  localparam int LIMIT      = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgFmt = 2'd0;
  logic [1:0]  cfgWidth = 2'd0;
  logic        bclk = 1'b0;
  logic        lrclk = 1'b0;
  logic        sdIn = 1'b0;
  logic [23:0] txLeft = '0;
  logic [23:0] txRight = '0;
  logic        sdOut, txTaken, rxValid;
  logic [23:0] rxLeft, rxRight;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int vCnt, tCnt;
  logic [23:0] gotL, gotR;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_serial_port u_dut (
    .clk(clk), .rstN(rstN), .cfgFmt(cfgFmt), .cfgWidth(cfgWidth),
    .bclk(bclk), .lrclk(lrclk), .sdIn(sdIn), .txLeft(txLeft), .txRight(txRight),
    .sdOut(sdOut), .txTaken(txTaken), .rxLeft(rxLeft), .rxRight(rxRight),
    .rxValid(rxValid)
  );

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
    cycles++;
    if (rxValid) begin vCnt++; gotL = rxLeft; gotR = rxRight; end
    if (txTaken) tCnt++;
    if (cycles > LIMIT) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<=%0d", cycles, LIMIT);
      finishRun();
    end
  endtask

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic int wOf(input int code);
    case (code)
      0: return 24; 1: return 20; 2: return 18; default: return 16;
    endcase
  endfunction

  function automatic logic [23:0] maskOf(input int w);
    return ~24'h0 << (24 - w);
  endfunction

  // {inWindow, bit} for bit period k of a 64-period frame, left half first.
  function automatic logic [1:0] expBit(input int fmt, input int w, input int k,
                                        input logic [23:0] l, input logic [23:0] r);
    int h, p, first;
    logic [23:0] word;
    if (fmt == 3) begin
      if (k < w)          return {1'b1, l[23-k]};
      else if (k < 2 * w) return {1'b1, r[23-(k-w)]};
      else                return 2'b00;
    end
    h = k / 32;
    p = k % 32;
    first = (fmt == 0) ? 1 : (fmt == 1) ? 0 : 32 - w;
    word = (h != 0) ? r : l;
    if (p >= first && p < first + w) return {1'b1, word[23-(p-first)]};
    return 2'b00;
  endfunction

  function automatic logic lrOf(input int fmt, input int k, input int pat);
    if (fmt == 3) return (pat != 0) ? (k < 4) : (k == 0);
    if (fmt == 0) return (k >= 32);
    return (k < 32);
  endfunction

  function automatic string tagOf(input int fmt);
    case (fmt)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic runFrame(input int fmt, input int wc, input int pat,
                          input logic [23:0] rl, input logic [23:0] rr,
                          input logic [23:0] tl, input logic [23:0] tr,
                          input bit doCheck, input bit burst);
    int w;
    logic [1:0] e;
    logic [63:0] txGot, txExp;
    w = wOf(wc);
    vCnt = 0; tCnt = 0; txGot = '0; txExp = '0;
    cfgFmt = 2'(fmt); cfgWidth = 2'(wc);
    txLeft = tl; txRight = tr;
    for (int k = 0; k < 64; k++) begin
      bclk = 1'b0;
      lrclk = lrOf(fmt, k, pat);
      e = expBit(fmt, w, k, rl, rr);
      sdIn = e[1] ? e[0] : 1'b1;   // noise outside the window
      if (k == 40) begin txLeft = ~tl; txRight = ~tr; end
      repeat (HALF_PH) tick();
      if (burst && (k % 8 == 3)) repeat (40) tick();
      txGot[63-k] = sdOut;
      e = expBit(fmt, w, k, tl, tr);
      txExp[63-k] = e[1] & e[0];
      bclk = 1'b1;
      repeat (HALF_PH) tick();
    end
    if (doCheck) begin
      chk(vCnt == 1, {tagOf(fmt), " R8 rxValid pulse count"}, 64'(vCnt), 64'd1);
      chk(gotL == (rl & maskOf(w)), {tagOf(fmt), " R6 R7 rx left"}, 64'(gotL), 64'(rl & maskOf(w)));
      chk(gotR == (rr & maskOf(w)), {tagOf(fmt), " R6 R7 rx right"}, 64'(gotR), 64'(rr & maskOf(w)));
      chk(txGot == txExp, {tagOf(fmt), " R6 R9 R10 tx stream", burst ? " R11" : ""}, txGot, txExp);
      chk(tCnt == 1, {tagOf(fmt), " R10 txTaken count"}, 64'(tCnt), 64'd1);
    end
  endtask

  initial begin
    logic [23:0] l, r;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk(!rxValid && !txTaken && !sdOut, "R1 reset strobes", {61'b0, rxValid, txTaken, sdOut}, 64'd0);
    chk(rxLeft == '0 && rxRight == '0, "R1 reset samples", {16'b0, rxLeft, rxRight}, 64'd0);

    for (int fmt = 0; fmt < 4; fmt++) begin
      for (int wc = 0; wc < 4; wc++) begin
        for (int pat = 0; pat < 2; pat++) begin
          l = 24'h9A3C5F + 24'(pat) * 24'h135791 + 24'(fmt * 4 + wc) * 24'h0F0F01;
          r = ~l ^ 24'h5A5A5A;
          runFrame(fmt, wc, pat, r, l, 24'h123456, 24'h7BCDEF, 1'b0, 1'b0);
          runFrame(fmt, wc, pat, l, r, r ^ 24'h0FF0F0, l ^ 24'h333333, 1'b1, 1'b0);
        end
      end
    end

    // R11: paused bit clock in I2S (16 bit) and left-justified (20 bit)
    runFrame(0, 3, 0, 24'hA1B2C3, 24'h4D5E6F, 24'h111111, 24'h222222, 1'b0, 1'b1);
    runFrame(0, 3, 0, 24'hC0FFEE, 24'h8BADF0, 24'hF00D12, 24'h5A5AA5, 1'b1, 1'b1);
    runFrame(1, 1, 0, 24'h13579B, 24'h2468AC, 24'h333333, 24'h444444, 1'b0, 1'b1);
    runFrame(1, 1, 0, 24'hE1E2E3, 24'h717273, 24'h9F8E7D, 24'h6C5B4A, 1'b1, 1'b1);

    finishRun();
  end

endmodule